// File: doc/BRIEF.md
# Instruction Fetch Cache with Tail Fill

A direct-mapped instruction cache placed between a processor's fetch port and a memory read port that returns one 32-bit word per accepted request. The cache keeps 256 lines of four words. When a fetch misses, it reads only the tail of the line, from the requested word up to the last word. It then records the full request address as the line tag. A later fetch hits only if it lies in the same 16-byte line and is not below that recorded address, so words that were never loaded are never returned.

Fetches at or above the cacheable limit skip the arrays and go to memory as single uncached reads. A global invalidate input clears every tag in one cycle. The processor drives it at start-up and when it isolates the cache. If it arrives while a fill is in progress, the fill is abandoned and the pending fetch is handled again as a fresh miss. A memory error during a fill or an uncached read produces an all-zero instruction.

Top module: `ifetch_cache`

## Requirements
- R1: After reset `req_ready_o` and `mem_req_o` are low, and the first fetch to any cacheable address is a miss that reads memory.
- R2: A fetch in the same line as the stored tag (address bits [31:4] equal) and not numerically below it is a hit. `req_ready_o` rises in the same cycle, no memory read is made, and `rsp_data_o` holds the word chosen by address bits [3:2].
- R3: On a miss the full request address becomes the tag. Memory reads go out in ascending word order, from the word chosen by bits [3:2] through word 3, one per acknowledge. From offset n, `req_ready_o` rises 5-n cycles after the request is first presented.
- R4: A fetch to a lower word of a line that was only partly filled (address below the stored tag) is a miss, and it refills from that lower word to word 3.
- R5: The line index is address bits [11:4]. A fetch whose bits [31:4] differ from the stored tag of its line misses and replaces that line.
- R6: A fetch at or above 0xA0000000 makes exactly one memory read at its word-aligned address and returns the memory word two cycles after the request. It is never cached, so a repeated fetch reads memory again.
- R7: A memory error during a fill ends the fill. The fetch returns zero and the line is invalidated, so the next fetch to it misses.
- R8: `inv_i` sets every tag to all ones, so each cacheable fetch afterwards misses. A hit-eligible fetch presented in the same cycle as `inv_i` is not accepted.
- R9: `inv_i` during a fill aborts it. The waiting fetch is then served as a new miss covering words from its offset to 3, and it returns the correct word.
- R10: While a miss is being served `req_ready_o` stays low. `mem_req_o` and `mem_addr_o` hold steady until `mem_ack_i`.
- R11: A memory error on an uncached read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inv_i | input | 1 | Invalidate all tags; aborts a fill |
| req_valid_i | input | 1 | Fetch request valid, held until accepted |
| req_addr_i | input | 32 | Fetch byte address |
| req_ready_o | output | 1 | Fetch accepted, data valid this cycle |
| rsp_data_o | output | 32 | Returned instruction word |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Word-aligned memory read address |
| mem_ack_i | input | 1 | Memory read accepted and data present |
| mem_data_i | input | 32 | Memory read data |
| mem_err_i | input | 1 | Memory read hit an unmapped address |

## Verification
Each result has a known due cycle:
- A hit is due in the same cycle the request is presented.
- A miss at word offset n is due 5-n cycles later when memory acknowledges at once.
- An uncached read is due two cycles later.
- A fill that hits an error on its k-th read is due k+1 cycles later.

The bench drives inputs on the falling edge and samples one nanosecond later. It counts falling edges until `req_ready_o` is seen and compares that count with the expected latency. It also compares the memory reads made since the request, and the first read address, with values derived from the address offset. The abort and stall cases hold off the memory acknowledge cycle by cycle, so the cycle in which the invalidate lands is fixed.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_BYP,
    ST_RESP
  } ifc_state_e;
endpackage

// File: rtl/ifc_store.sv
module ifc_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_all_i,
  input  logic              tag_we_i,
  input  logic [IDX_W-1:0]  tag_idx_i,
  input  logic [ADDR_W-1:0] tag_val_i,
  input  logic              dat_we_i,
  input  logic [IDX_W-1:0]  dat_idx_i,
  input  logic [OFF_W-1:0]  dat_word_i,
  input  logic [DATA_W-1:0] dat_val_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_word_i,
  output logic [ADDR_W-1:0] rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int ENTRIES = LINES * WORDS;

  logic [ADDR_W-1:0] tag_q  [LINES];
  logic [DATA_W-1:0] data_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
    end else if (inv_all_i) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
    end else if (tag_we_i) begin
      tag_q[tag_idx_i] <= tag_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) data_q[i] <= '1;
    end else if (dat_we_i) begin
      data_q[{dat_idx_i, dat_word_i}] <= dat_val_i;
    end
  end

  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_data_o = data_q[{rd_idx_i, rd_word_i}];
endmodule

// File: rtl/ifc_hit.sv
module ifc_hit #(
  parameter int              ADDR_W      = 32,
  parameter int              LINE_LSB    = 4,
  parameter logic [ADDR_W-1:0] CACHE_LIMIT = 32'hA000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] tag_i,
  output logic              cacheable_o,
  output logic              hit_o
);
  logic same_line;
  logic not_below;

  assign cacheable_o = addr_i < CACHE_LIMIT;
  assign same_line   = tag_i[ADDR_W-1:LINE_LSB] == addr_i[ADDR_W-1:LINE_LSB];
  // words below the fill start were never loaded
  assign not_below   = addr_i >= tag_i;
  assign hit_o       = same_line && not_below;
endmodule

// File: rtl/ifc_fill_seq.sv
module ifc_fill_seq
  import ifc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  localparam int IDX_W    = $clog2(LINES),
  localparam int OFF_W    = $clog2(WORDS),
  localparam int BYTE_LSB = $clog2(DATA_W / 8),
  localparam int LINE_LSB = BYTE_LSB + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              cacheable_i,
  input  logic              hit_i,
  output logic              req_ready_o,
  output logic              use_resp_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              mem_err_i,
  output logic              tag_we_o,
  output logic [IDX_W-1:0]  tag_idx_o,
  output logic [ADDR_W-1:0] tag_val_o,
  output logic              dat_we_o,
  output logic [IDX_W-1:0]  dat_idx_o,
  output logic [OFF_W-1:0]  dat_word_o,
  output logic [DATA_W-1:0] dat_val_o
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(DATA_W / 8);

  ifc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] resp_q, resp_d;
  logic [ADDR_W-1:0] req_aligned;
  logic              last_word;

  assign req_aligned = {req_addr_i[ADDR_W-1:BYTE_LSB], {BYTE_LSB{1'b0}}};
  assign last_word   = &addr_q[BYTE_LSB +: OFF_W];

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    resp_d      = resp_q;
    req_ready_o = 1'b0;
    mem_req_o   = 1'b0;
    tag_we_o    = 1'b0;
    tag_idx_o   = req_addr_i[LINE_LSB +: IDX_W];
    tag_val_o   = req_addr_i;
    dat_we_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i && !inv_i) begin
          if (!cacheable_i) begin
            state_d = ST_BYP;
            addr_d  = req_aligned;
          end else if (hit_i) begin
            req_ready_o = 1'b1;
          end else begin
            tag_we_o = 1'b1;
            state_d  = ST_FILL;
            addr_d   = req_aligned;
          end
        end
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (inv_i) begin
          state_d = ST_IDLE;
        end else if (mem_ack_i) begin
          if (mem_err_i) begin
            // drop the partly filled line
            tag_we_o  = 1'b1;
            tag_idx_o = addr_q[LINE_LSB +: IDX_W];
            tag_val_o = '1;
            resp_d    = '0;
            state_d   = ST_RESP;
          end else begin
            dat_we_o = 1'b1;
            if (last_word) state_d = ST_IDLE;
            else           addr_d  = addr_q + WORD_BYTES;
          end
        end
      end
      ST_BYP: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          resp_d  = mem_err_i ? '0 : mem_data_i;
          state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        req_ready_o = req_valid_i;
        if (req_valid_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      resp_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      resp_q  <= resp_d;
    end
  end

  assign use_resp_o  = state_q == ST_RESP;
  assign resp_data_o = resp_q;
  assign mem_addr_o  = addr_q;
  assign dat_idx_o   = addr_q[LINE_LSB +: IDX_W];
  assign dat_word_o  = addr_q[BYTE_LSB +: OFF_W];
  assign dat_val_o   = mem_data_i;
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter int                LINES       = 256,
  parameter int                WORDS       = 4,
  parameter logic [ADDR_W-1:0] CACHE_LIMIT = 32'hA000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              mem_err_i
);
  localparam int IDX_W    = $clog2(LINES);
  localparam int OFF_W    = $clog2(WORDS);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);
  localparam int LINE_LSB = BYTE_LSB + OFF_W;

  logic [ADDR_W-1:0] rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              cacheable, hit;
  logic              use_resp;
  logic [DATA_W-1:0] resp_data;
  logic              tag_we, dat_we;
  logic [IDX_W-1:0]  tag_idx, dat_idx;
  logic [ADDR_W-1:0] tag_val;
  logic [OFF_W-1:0]  dat_word;
  logic [DATA_W-1:0] dat_val;

  ifc_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inv_all_i (inv_i),
    .tag_we_i  (tag_we),
    .tag_idx_i (tag_idx),
    .tag_val_i (tag_val),
    .dat_we_i  (dat_we),
    .dat_idx_i (dat_idx),
    .dat_word_i(dat_word),
    .dat_val_i (dat_val),
    .rd_idx_i  (req_addr_i[LINE_LSB +: IDX_W]),
    .rd_word_i (req_addr_i[BYTE_LSB +: OFF_W]),
    .rd_tag_o  (rd_tag),
    .rd_data_o (rd_data)
  );

  ifc_hit #(
    .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .CACHE_LIMIT(CACHE_LIMIT)
  ) u_hit (
    .addr_i     (req_addr_i),
    .tag_i      (rd_tag),
    .cacheable_o(cacheable),
    .hit_o      (hit)
  );

  ifc_fill_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inv_i      (inv_i),
    .req_valid_i(req_valid_i),
    .req_addr_i (req_addr_i),
    .cacheable_i(cacheable),
    .hit_i      (hit),
    .req_ready_o(req_ready_o),
    .use_resp_o (use_resp),
    .resp_data_o(resp_data),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .mem_data_i (mem_data_i),
    .mem_err_i  (mem_err_i),
    .tag_we_o   (tag_we),
    .tag_idx_o  (tag_idx),
    .tag_val_o  (tag_val),
    .dat_we_o   (dat_we),
    .dat_idx_o  (dat_idx),
    .dat_word_o (dat_word),
    .dat_val_o  (dat_val)
  );

  assign rsp_data_o = use_resp ? resp_data : rd_data;
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
  parameter int                ADDR_W      = 32,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] CACHE_LIMIT = 32'hA000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inv_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_ready_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              mem_err_i
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(DATA_W / 8);
  localparam int BYTE_LSB = $clog2(DATA_W / 8);

  AST_RDY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i); // R10

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R10

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !inv_i) |=> (mem_req_o && $stable(mem_addr_o))); // R10

  AST_FILL_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_err_i && !inv_i && (mem_addr_o < CACHE_LIMIT)
     && !(&mem_addr_o[BYTE_LSB +: 2]))
    |=> (mem_req_o && (mem_addr_o == $past(mem_addr_o) + WORD_BYTES))); // R3

  AST_FILL_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_err_i && !inv_i && (mem_addr_o < CACHE_LIMIT)
     && (&mem_addr_o[BYTE_LSB +: 2]))
    |=> !mem_req_o); // R3

  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i && !inv_i) |=> (rsp_data_o == '0)); // R7

  AST_INV_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !(req_ready_o && (req_addr_i < CACHE_LIMIT))); // R8
endmodule

bind ifetch_cache ifetch_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CACHE_LIMIT(CACHE_LIMIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inv_i      (inv_i),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_ready_o(req_ready_o),
  .rsp_data_o (rsp_data_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .mem_err_i  (mem_err_i)
);

// File: tb/tb_ifetch_cache.sv
`timescale 1ns/1ps
module tb_ifetch_cache;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inv_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_ready_o;
  logic [31:0] rsp_data_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i;
  logic [31:0] mem_data_i;
  logic        mem_err_i;

  logic        ack_en = 1'b1;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int          n_chk = 0;
  int          n_fail = 0;
  int          rd_total = 0;
  logic [31:0] rd_hist [16];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
  endfunction

  assign mem_ack_i  = mem_req_o & ack_en;
  assign mem_data_i = mem_word(mem_addr_o);
  assign mem_err_i  = mem_addr_o == err_addr;

  always @(posedge clk) begin
    if (mem_req_o && mem_ack_i) begin
      rd_hist[rd_total % 16] <= mem_addr_o;
      rd_total <= rd_total + 1;
    end
  end

  ifetch_cache dut (
    .clk_i(clk), .rst_ni(rst_ni), .inv_i(inv_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_ready_o(req_ready_o), .rsp_data_o(rsp_data_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_data_i(mem_data_i), .mem_err_i(mem_err_i)
  );

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // valid already driven; wait for acceptance
  task automatic wait_ready(output logic [31:0] d, output int lat);
    bit got = 1'b0;
    lat = 0;
    d = '0;
    #1;
    while (!got && lat <= 60) begin
      if (req_ready_o) begin
        d = rsp_data_o;
        got = 1'b1;
      end else begin
        @(negedge clk);
        #1;
        lat++;
      end
    end
  endtask

  task automatic fetch(input logic [31:0] a, output logic [31:0] d,
                       output int lat, output int nrd, output logic [31:0] first);
    int s;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    s = rd_total;
    wait_ready(d, lat);
    nrd   = rd_total - s;
    first = rd_hist[s % 16];
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  function automatic string rtag(input int k);
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R3";
    endcase
  endfunction

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  reads;
    logic [3:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1008, 4'd2, 4'd3, 4'd1},  // first fetch misses, tail fill
    '{32'h0000_100C, 4'd0, 4'd0, 4'd2},  // hit
    '{32'h0000_1004, 4'd3, 4'd4, 4'd4},  // below tag
    '{32'h0000_1008, 4'd0, 4'd0, 4'd2},
    '{32'h0000_1000, 4'd4, 4'd5, 4'd4},
    '{32'h0000_2000, 4'd4, 4'd5, 4'd5},  // same index, other tag
    '{32'h0000_1000, 4'd4, 4'd5, 4'd5},  // evicted
    '{32'h8000_0FF0, 4'd4, 4'd5, 4'd3},
    '{32'h8000_0FFC, 4'd0, 4'd0, 4'd2},
    '{32'hA000_0000, 4'd1, 4'd2, 4'd6},  // uncached
    '{32'hA000_0000, 4'd1, 4'd2, 4'd6},
    '{32'h9FFF_FFFC, 4'd1, 4'd2, 4'd3},  // top of cacheable range
    '{32'h9FFF_FFFC, 4'd0, 4'd0, 4'd2},
    '{32'hBFC0_0102, 4'd1, 4'd2, 4'd6}
  };

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, first, a;
    int lat, nrd, s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready_o == 1'b0, "R1", "ready after reset", 32'(req_ready_o), 0);
    chk(mem_req_o == 1'b0, "R1", "mem_req after reset", 32'(mem_req_o), 0);

    for (int i = 0; i < NV; i++) begin
      a = VECS[i].addr;
      fetch(a, d, lat, nrd, first);
      chk(d == mem_word({a[31:2], 2'b00}), rtag(VECS[i].req), "data", d, mem_word({a[31:2], 2'b00}));
      chk(lat == int'(VECS[i].lat), "R10", "latency", 32'(lat), 32'(VECS[i].lat));
      chk(nrd == int'(VECS[i].reads), rtag(VECS[i].req), "reads", 32'(nrd), 32'(VECS[i].reads));
      if (VECS[i].reads != 0)
        chk(first == {a[31:2], 2'b00}, "R3", "first read addr", first, {a[31:2], 2'b00});
    end

    // R7: error on second fill word
    err_addr = 32'h0000_3008;
    fetch(32'h0000_3004, d, lat, nrd, first);
    chk(d == 32'h0, "R7", "fill error data", d, 0);
    chk(lat == 3, "R7", "fill error latency", 32'(lat), 3);
    chk(nrd == 2, "R7", "fill error reads", 32'(nrd), 2);
    err_addr = 32'hFFFF_FFFF;
    fetch(32'h0000_3004, d, lat, nrd, first);
    chk(nrd == 3, "R7", "line dropped after error", 32'(nrd), 3);
    chk(d == mem_word(32'h0000_3004), "R7", "refetch data", d, mem_word(32'h0000_3004));

    // R11: error on uncached read
    err_addr = 32'hA000_0040;
    fetch(32'hA000_0040, d, lat, nrd, first);
    chk(d == 32'h0, "R11", "bypass error data", d, 0);
    chk(nrd == 1, "R11", "bypass error reads", 32'(nrd), 1);
    err_addr = 32'hFFFF_FFFF;

    // R8: invalidate while idle
    fetch(32'h0000_4000, d, lat, nrd, first);
    fetch(32'h0000_4000, d, lat, nrd, first);
    chk(nrd == 0, "R8", "hit before invalidate", 32'(nrd), 0);
    @(negedge clk); inv_i = 1'b1;
    @(negedge clk); inv_i = 1'b0;
    fetch(32'h0000_4000, d, lat, nrd, first);
    chk(nrd == 4, "R8", "miss after invalidate", 32'(nrd), 4);

    // R8: invalidate in the same cycle as a hit-eligible fetch
    fetch(32'h0000_6000, d, lat, nrd, first);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 32'h0000_6000; inv_i = 1'b1;
    s = rd_total;
    #1;
    chk(req_ready_o == 1'b0, "R8", "hit blocked by invalidate", 32'(req_ready_o), 0);
    @(negedge clk); inv_i = 1'b0;
    wait_ready(d, lat);
    chk(rd_total - s == 4, "R8", "same-cycle invalidate reads", 32'(rd_total - s), 4);
    chk(d == mem_word(32'h0000_6000), "R8", "data after invalidate", d, mem_word(32'h0000_6000));
    @(negedge clk); req_valid_i = 1'b0;

    // R9 / R10: stall, partial fill, abort by invalidate
    @(negedge clk);
    ack_en = 1'b0;
    req_valid_i = 1'b1; req_addr_i = 32'h0000_5000;
    s = rd_total;
    @(negedge clk); #1;
    chk(mem_req_o && mem_addr_o == 32'h0000_5000, "R10", "fill request", mem_addr_o, 32'h0000_5000);
    @(negedge clk); #1;
    chk(mem_req_o && mem_addr_o == 32'h0000_5000 && !req_ready_o, "R10", "stall hold",
        mem_addr_o, 32'h0000_5000);
    ack_en = 1'b1;
    @(negedge clk);
    ack_en = 1'b0; inv_i = 1'b1;
    @(negedge clk);
    inv_i = 1'b0; ack_en = 1'b1;
    wait_ready(d, lat);
    chk(rd_total - s == 5, "R9", "reads incl. retry", 32'(rd_total - s), 5);
    chk(d == mem_word(32'h0000_5000), "R9", "retry data", d, mem_word(32'h0000_5000));
    @(negedge clk); req_valid_i = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule